// File: doc/BRIEF.md
# Cascaded Seven-Segment Register Driver

This block drives a series chain of latched shift-register devices that hold two seven-segment digits, each with a decimal point. Each device passes its serial cascade output on to the next device's serial input. The shift clocks of all devices share one line, and so do their storage clocks. The whole chain therefore needs four lines from the block: serial data, shift clock, storage clock and an active-low output enable. A fifth line, the chain clear, is used only during start-up.

A host hands over a 16-bit frame with a valid/ready handshake. The block shifts the frame out most-significant bit first on `ser_data` and `shift_clk`. It then pulses `store_clk` once so that the whole frame reaches the device outputs at the same moment. The frame already on display stays visible while the new one shifts in. The length of each shift-clock half period is set by an input. Display brightness is set by pulse-width modulating `out_en_n` from an 8-bit duty input.

After reset the block clears the shift stages and latches them once, so the display starts blank with all outputs at zero.

Top module: `segchain_driver`

## Requirements
- R1: While `rst_n` is low: `shift_clk`, `store_clk` and `frm_ready` are low, `chain_clr_n` is low and `out_en_n` is high.
- R2: After reset release, `chain_clr_n` stays low up to and through one `store_clk` pulse. `chain_clr_n` then goes high and `frm_ready` rises. A chain model driven by the block's lines then shows 16'h0000.
- R3: A frame is taken on a rising clock edge where `frm_valid` and `frm_ready` are both high. `frm_ready` stays low from that edge until the `store_clk` pulse has ended. A frame held valid while the block is busy is taken later and is not lost.
- R4: Each frame gives exactly 16 `shift_clk` rising edges, bit 15 first. The chain shifts one stage per edge, and the first bit ends on the last stage of the far device. After the storage pulse, the 16 chain outputs (far device last output = bit 15) equal the frame.
- R5: `ser_data` never changes while `shift_clk` is high. Before every `shift_clk` rising edge, it has been stable for at least one half period.
- R6: Each frame gives exactly one `store_clk` pulse, and none while `shift_clk` is high. The pulse rises at least one half period after the last `shift_clk` falling edge. Until that pulse, the chain outputs keep showing the previous frame.
- R7: Every high and every low half period of `shift_clk` within a frame lasts H system clocks. H is `half_cycles`, and a value of 0 counts as 1.
- R8: While `bright_duty` stays at D, `out_en_n` is low in exactly D of every 256 consecutive clocks.
- R9: A duty of 0 keeps `out_en_n` high on every clock. A duty of 255 keeps it high for exactly one clock in every 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frm_valid | input | 1 | Host offers a frame |
| frm_data | input | 16 | Frame bits; bit 15 goes to the last output of the far device |
| frm_ready | output | 1 | Block can take a frame |
| half_cycles | input | 8 | Shift-clock half period in system clocks (0 counts as 1) |
| bright_duty | input | 8 | Brightness duty, enabled counts per 256 |
| ser_data | output | 1 | Serial data to the first device |
| shift_clk | output | 1 | Shared shift clock |
| store_clk | output | 1 | Shared storage clock |
| chain_clr_n | output | 1 | Active-low clear of the shift stages |
| out_en_n | output | 1 | Active-low output enable carrying brightness PWM |

## Verification
The embedded assertions check four rules on every cycle: serial data holds while the shift clock is high, the storage clock never overlaps shifting, ready stays low through shifting and latching, and the clear is released only after the start-up latch. They also check the two duty extremes of the enable signal. Other behaviour only shows up in the bench's scenarios, which run a behavioural model of the two-device chain. These cover the bit order and the final displayed value, the measured half-period widths for each setting, the setup margin before each shift edge, and the gap before the latch. They also cover a frame held off behind a busy one, and the exact count of enabled clocks per 256 for several duties.

// File: rtl/seg_pkg.sv
package seg_pkg;
  typedef enum logic [2:0] {
    ST_CLR      = 3'd0,
    ST_INIT_LAT = 3'd1,
    ST_IDLE     = 3'd2,
    ST_LO       = 3'd3,
    ST_HI       = 3'd4,
    ST_GAP      = 3'd5,
    ST_LAT      = 3'd6
  } seg_state_e;
endpackage

// File: rtl/seg_rst_sync.sv
module seg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/seg_phase_timer.sv
module seg_phase_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [CNT_W-1:0] half_cycles,
  output logic             done
);
  logic [CNT_W-1:0] timer_q, timer_d;
  logic [CNT_W-1:0] hp_eff;
  logic             timer_en;

  assign hp_eff = (half_cycles == '0) ? CNT_W'(1) : half_cycles;

  always_comb begin
    timer_en = 1'b0;
    timer_d  = timer_q;
    if (restart) begin
      timer_en = 1'b1;
      timer_d  = hp_eff - CNT_W'(1);
    end else if (timer_q != '0) begin
      timer_en = 1'b1;
      timer_d  = timer_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        timer_q <= '0;
    else if (timer_en) timer_q <= timer_d;
  end

  assign done = (timer_q == '0);

  a_r7_restart_loads: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(restart) && $past(half_cycles) <= CNT_W'(1)) |-> done);
endmodule

// File: rtl/seg_serializer.sv
module seg_serializer
  import seg_pkg::*;
#(
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frm_valid,
  input  logic [FRAME_W-1:0] frm_data,
  output logic               frm_ready,
  input  logic               phase_done,
  output logic               phase_restart,
  output logic               ser_data,
  output logic               shift_clk,
  output logic               store_clk,
  output logic               chain_clr_n
);
  localparam int BIT_W = (FRAME_W > 1) ? $clog2(FRAME_W) : 1;

  seg_state_e         state_q, state_d;
  logic [FRAME_W-1:0] shreg_q, shreg_d;
  logic [BIT_W-1:0]   bitc_q, bitc_d;
  logic               sdo_q, sdo_d;
  logic               sclk_q, lclk_q, clr_n_q;
  logic               data_en;

  always_comb begin
    state_d       = state_q;
    shreg_d       = shreg_q;
    bitc_d        = bitc_q;
    sdo_d         = sdo_q;
    data_en       = 1'b0;
    phase_restart = 1'b0;
    unique case (state_q)
      ST_CLR: if (phase_done) begin
        state_d       = ST_INIT_LAT;
        phase_restart = 1'b1;
      end
      ST_INIT_LAT: if (phase_done) state_d = ST_IDLE;
      ST_IDLE: if (frm_valid) begin
        data_en       = 1'b1;
        shreg_d       = frm_data;
        sdo_d         = frm_data[FRAME_W-1];
        bitc_d        = BIT_W'(FRAME_W - 1);
        state_d       = ST_LO;
        phase_restart = 1'b1;
      end
      ST_LO: if (phase_done) begin
        state_d       = ST_HI;
        phase_restart = 1'b1;
      end
      ST_HI: if (phase_done) begin
        phase_restart = 1'b1;
        data_en       = 1'b1;
        if (bitc_q == '0) begin
          sdo_d   = 1'b0;
          state_d = ST_GAP;
        end else begin
          shreg_d = {shreg_q[FRAME_W-2:0], 1'b0};
          sdo_d   = shreg_q[FRAME_W-2];
          bitc_d  = bitc_q - BIT_W'(1);
          state_d = ST_LO;
        end
      end
      ST_GAP: if (phase_done) begin
        state_d       = ST_LAT;
        phase_restart = 1'b1;
      end
      ST_LAT: if (phase_done) state_d = ST_IDLE;
      default: state_d = ST_CLR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_CLR;
      sclk_q  <= 1'b0;
      lclk_q  <= 1'b0;
      clr_n_q <= 1'b0;
    end else begin
      state_q <= state_d;
      sclk_q  <= (state_d == ST_HI);
      lclk_q  <= (state_d == ST_LAT) || (state_d == ST_INIT_LAT);
      clr_n_q <= !((state_d == ST_CLR) || (state_d == ST_INIT_LAT));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      bitc_q  <= '0;
      sdo_q   <= 1'b0;
    end else if (data_en) begin
      shreg_q <= shreg_d;
      bitc_q  <= bitc_d;
      sdo_q   <= sdo_d;
    end
  end

  assign frm_ready   = (state_q == ST_IDLE);
  assign ser_data    = sdo_q;
  assign shift_clk   = sclk_q;
  assign store_clk   = lclk_q;
  assign chain_clr_n = clr_n_q;

  a_r5_data_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_q && $past(sclk_q)) |-> $stable(sdo_q));
  a_r6_no_latch_in_shift: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_q |-> !lclk_q);
  a_r3_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_q || lclk_q) |-> !frm_ready);
  a_r2_clear_after_latch: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clr_n_q) |-> $past(lclk_q));
endmodule

// File: rtl/seg_pwm.sv
module seg_pwm #(
  parameter int PWM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PWM_W-1:0] duty,
  output logic             oe_n
);
  logic [PWM_W-1:0] cnt_q, cnt_d;
  logic             oe_n_q, oe_n_d;

  always_comb begin
    cnt_d  = cnt_q + PWM_W'(1);
    oe_n_d = !(cnt_q < duty);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      oe_n_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      oe_n_q <= oe_n_d;
    end
  end

  assign oe_n = oe_n_q;

  a_r9_zero_duty_blank: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(duty) == '0) |-> oe_n_q);
  a_r9_full_duty_lit: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(duty) == '1 && $past(cnt_q) != '1) |-> !oe_n_q);
endmodule

// File: rtl/segchain_driver.sv
module segchain_driver #(
  parameter int DEVICES  = 2,
  parameter int DEV_BITS = 8,
  parameter int HALF_W   = 8,
  parameter int PWM_W    = 8,
  localparam int FRAME_W = DEVICES * DEV_BITS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frm_valid,
  input  logic [FRAME_W-1:0] frm_data,
  output logic               frm_ready,
  input  logic [HALF_W-1:0]  half_cycles,
  input  logic [PWM_W-1:0]   bright_duty,
  output logic               ser_data,
  output logic               shift_clk,
  output logic               store_clk,
  output logic               chain_clr_n,
  output logic               out_en_n
);
  logic rst_s_n;
  logic phase_done, phase_restart;

  seg_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n_i(rst_n), .rst_n_o(rst_s_n)
  );

  seg_phase_timer #(.CNT_W(HALF_W)) u_timer (
    .clk(clk), .rst_n(rst_s_n), .restart(phase_restart),
    .half_cycles(half_cycles), .done(phase_done)
  );

  seg_serializer #(.FRAME_W(FRAME_W)) u_ser (
    .clk(clk), .rst_n(rst_s_n), .frm_valid(frm_valid), .frm_data(frm_data),
    .frm_ready(frm_ready), .phase_done(phase_done), .phase_restart(phase_restart),
    .ser_data(ser_data), .shift_clk(shift_clk), .store_clk(store_clk),
    .chain_clr_n(chain_clr_n)
  );

  seg_pwm #(.PWM_W(PWM_W)) u_pwm (
    .clk(clk), .rst_n(rst_s_n), .duty(bright_duty), .oe_n(out_en_n)
  );
endmodule

// File: tb/sim_segchain_driver.sv
module sim_segchain_driver;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        frm_valid;
  logic [15:0] frm_data;
  logic        frm_ready;
  logic [7:0]  half_cycles;
  logic [7:0]  bright_duty;
  logic        ser_data, shift_clk, store_clk, chain_clr_n, out_en_n;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit finished = 0;

  segchain_driver u0 (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_data(frm_data),
    .frm_ready(frm_ready), .half_cycles(half_cycles), .bright_duty(bright_duty),
    .ser_data(ser_data), .shift_clk(shift_clk), .store_clk(store_clk),
    .chain_clr_n(chain_clr_n), .out_en_n(out_en_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int eff_half(input logic [7:0] h);
    return (h == 8'd0) ? 1 : int'(h);
  endfunction

  function automatic int exp_lit(input logic [7:0] d);
    return int'(d);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural model of two cascaded latched shift registers
  logic [15:0] chain, disp, exp_shown;
  logic p_sclk = 1'b0, p_lclk = 1'b0, p_sdo = 1'b0;
  int stable = 0, hi_cnt = 0, lo_cnt = 0, since_fall = 0;
  int bit_idx = 0, sclk_rises = 0, lclk_rises = 0, h_eff = 1;
  bit mid_en = 0;

  always @(negedge clk) begin
    if (!chain_clr_n) chain = 16'h0000;
    if (ser_data !== p_sdo) stable = 1; else stable++;
    since_fall++;
    if (!shift_clk) lo_cnt++;
    if (shift_clk) hi_cnt++;
    if (shift_clk && !p_sclk) begin
      chk(stable >= h_eff + 1, "R5 setup before shift edge", stable, h_eff + 1);
      chk(!frm_ready, "R3 ready low while shifting", frm_ready, 0);
      chk(!store_clk, "R6 no store pulse during shift", store_clk, 0);
      if (bit_idx > 0) chk(lo_cnt == h_eff, "R7 low half period", lo_cnt, h_eff);
      chain = {chain[14:0], ser_data};
      sclk_rises++;
      bit_idx++;
      hi_cnt = 1;
      if (mid_en && bit_idx == 8)
        chk(disp === exp_shown, "R6 old frame kept during shift", disp, exp_shown);
    end
    if (shift_clk && p_sclk && ser_data !== p_sdo)
      chk(0, "R5 data moved while shift clock high", ser_data, p_sdo);
    if (!shift_clk && p_sclk) begin
      chk(hi_cnt == h_eff, "R7 high half period", hi_cnt, h_eff);
      lo_cnt = 1;
      since_fall = 1;
    end
    if (store_clk && !p_lclk) begin
      disp = chain;
      lclk_rises++;
      if (chain_clr_n) begin
        chk(since_fall >= h_eff + 1, "R6 gap before store pulse", since_fall, h_eff + 1);
        chk(bit_idx == 16, "R4 shifts per frame", bit_idx, 16);
      end
      bit_idx = 0;
    end
    p_sclk = shift_clk;
    p_lclk = store_clk;
    p_sdo  = ser_data;
  end

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic send(input logic [15:0] d);
    frm_data  = d;
    frm_valid = 1'b1;
    while (!frm_ready) @(negedge clk);
    @(negedge clk);
    frm_valid = 1'b0;
  endtask

  task automatic wait_done();
    while (!frm_ready) @(negedge clk);
  endtask

  task automatic run_frame(input logic [15:0] d, input logic [7:0] h);
    int s0, l0;
    half_cycles = h;
    h_eff = eff_half(h);
    s0 = sclk_rises;
    l0 = lclk_rises;
    mid_en = 1;
    send(d);
    wait_done();
    chk(sclk_rises - s0 == 16, "R4 shift edge count", sclk_rises - s0, 16);
    chk(lclk_rises - l0 == 1, "R6 one store pulse", lclk_rises - l0, 1);
    chk(disp === d, "R4 displayed frame", disp, d);
    exp_shown = d;
  endtask

  task automatic pwm_check(input logic [7:0] d);
    int lit, hi;
    bright_duty = d;
    repeat (3) @(negedge clk);
    lit = 0;
    for (int i = 0; i < 256; i++) begin
      if (!out_en_n) lit++;
      @(negedge clk);
    end
    hi = 256 - lit;
    chk(lit == exp_lit(d), "R8 enabled clocks per period", lit, exp_lit(d));
    if (d == 8'd0) chk(hi == 256, "R9 zero duty blank", hi, 256);
    if (d == 8'hFF) chk(hi == 1, "R9 full duty one blank", hi, 1);
  endtask

  initial begin
    int s0, l0;
    logic [15:0] a, b;
    void'($urandom(32'h5EED));
    rst_n = 1'b0;
    frm_valid = 1'b0;
    frm_data = 16'h0;
    half_cycles = 8'd1;
    bright_duty = 8'd0;
    exp_shown = 16'h0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(!shift_clk && !store_clk, "R1 clocks low in reset", {shift_clk, store_clk}, 0);
    chk(!frm_ready, "R1 ready low in reset", frm_ready, 0);
    chk(!chain_clr_n, "R1 clear asserted in reset", chain_clr_n, 0);
    chk(out_en_n, "R1 outputs disabled in reset", out_en_n, 1);
    rst_n = 1'b1;
    wait_done();
    // R2 start-up sequence
    chk(lclk_rises == 1, "R2 one start-up latch", lclk_rises, 1);
    chk(chain_clr_n, "R2 clear released", chain_clr_n, 1);
    chk(disp === 16'h0000, "R2 display zero after start-up", disp, 0);

    run_frame(16'h8001, 8'd1);
    run_frame(16'hFFFF, 8'd3);
    run_frame(16'h0000, 8'd0);
    run_frame(16'hA5C3, 8'd2);
    run_frame(16'h1234, 8'd4);

    // R3 second frame held off while busy, not dropped
    a = 16'h0F0F;
    b = 16'hC0DE;
    half_cycles = 8'd2;
    h_eff = 2;
    mid_en = 0;
    s0 = sclk_rises;
    l0 = lclk_rises;
    send(a);
    send(b);
    wait_done();
    chk(lclk_rises - l0 == 2, "R3 both frames latched", lclk_rises - l0, 2);
    chk(sclk_rises - s0 == 32, "R3 both frames shifted", sclk_rises - s0, 32);
    chk(disp === b, "R3 held frame shown last", disp, b);
    exp_shown = b;

    for (int k = 0; k < 20; k++)
      run_frame(16'($urandom()), 8'($urandom_range(1, 4)));

    pwm_check(8'd0);
    pwm_check(8'hFF);
    pwm_check(8'd1);
    pwm_check(8'd128);
    for (int k = 0; k < 3; k++) pwm_check(8'($urandom()));

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule